// File: doc/BRIEF.md
# MAC Control, Soft-Reset and Interrupt Register Block

This block is the register slave of an Ethernet MAC. It holds the MAC control word, the interrupt enable and interrupt status words, and six configuration words: the transmit and receive descriptor list bases, the FIFO threshold, the maximum receive frame length, the missed-packet counter, and the management data word. The transmit and receive engines raise status bits through one-cycle set pulses. The block returns transmit-enable and receive-enable levels to those engines, and it produces one transmit interrupt line and one receive interrupt line.

Software can start a soft reset by writing the control word. The soft reset lasts a fixed number of clock cycles, 16 by default. While it runs, every register reads as zero and all register writes and status pulses are ignored. When it ends, the registers hold their defaults, and several of those defaults are non-zero. Software therefore polls a register with a non-zero default until it reads back non-zero. Reads use a single-cycle bus with combinational read data. Writes take effect at the clock edge on which `reg_we` is high.

Top module: `maccsr`

## Requirements
- R1: After hardware reset, the word addresses read as follows:
  - 0 (control), 1 (interrupt enable) and 2 (interrupt status) read 0.
  - 3 (transmit list base) and 4 (receive list base) read 0xFFFFFFFC.
  - 5 (FIFO threshold) reads 0x00000101.
  - 6 (maximum receive frame) reads 0x00000800.
  - 7 (missed-packet counter) reads 0x00007FFF.
  - 8 (management data) reads 0x00900000.
- R2: A write to address 0 with bit 24 set starts a soft reset that lasts 16 cycles. After it, bit 24 of address 0 reads 0 and every register reads its R1 value.
- R3: While a soft reset is running, every address reads 0.
- R4: While a soft reset is running, register writes and status set pulses have no effect. This includes a write of bit 24, so a running soft reset cannot be restarted. `tx_en`, `rx_en`, `irq_tx` and `irq_rx` are all 0 for the whole soft reset.
- R5: Control bit 8 drives `tx_en` and control bit 0 drives `rx_en`. Control bits 23:0 are writable and bits 31:24 read 0.
- R6: The interrupt enable and interrupt status words implement only bits 24:16 (transmit half) and 11:0 (receive half). All other bits read 0.
- R7: Writing address 2 clears each status bit written as 1 and leaves the other bits unchanged.
- R8: A bit of `sts_set` that is high sets the matching implemented status bit. If a clear write to the same bit lands in the same cycle, the set wins and the bit remains 1.
- R9: `irq_tx` is the OR of status[24:16] AND enable[24:16]. `irq_rx` is the OR of status[11:0] AND enable[11:0].
- R10: Bits 1:0 of both descriptor list base registers always read 0.
- R11: Addresses 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sts_set | input | 32 | Status set pulses from the engines |
| tx_en | output | 1 | Transmit engine enable |
| rx_en | output | 1 | Receive engine enable |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The hardest cases to reach from the ports are the coincidences. One is a set pulse and a write-one-to-clear hitting the same status bit on the same edge. Another is a write, a second reset request or a set pulse landing inside the 16-cycle soft-reset window, including on its first and last edges. Directed sequences place each of these on a chosen edge. Seeded random traffic then mixes sparse set pulses, clear writes and occasional soft resets, so that these collisions also occur at arbitrary points. After every edge, a cycle-level model in the bench predicts the read data, both enables and both interrupt lines.

// File: rtl/maccsr_pkg.sv
`timescale 1ns/1ps
package maccsr_pkg;

  localparam int DW      = 32;
  localparam int NCFG    = 6;
  localparam int A_CTRL  = 0;
  localparam int A_IEN   = 1;
  localparam int A_STAT  = 2;
  localparam int A_CFG0  = 3;

  localparam int CTRL_RST_BIT = 24;
  localparam int CTRL_TX_BIT  = 8;
  localparam int CTRL_RX_BIT  = 0;
  localparam logic [DW-1:0] CTRL_WMASK = 32'h00FF_FFFF;

  localparam int TXH_LO = 16;
  localparam int TXH_HI = 24;
  localparam int RXH_LO = 0;
  localparam int RXH_HI = 11;

  typedef enum logic [2:0] {
    CFG_TXLIST = 3'd0,
    CFG_RXLIST = 3'd1,
    CFG_FIFOTH = 3'd2,
    CFG_MAXRX  = 3'd3,
    CFG_MISS   = 3'd4,
    CFG_MDIO   = 3'd5
  } cfg_e;

  // contiguous mask of bits lo..hi
  function automatic logic [DW-1:0] span_mask(input int lo, input int hi);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DW-1:0] TX_MASK  = span_mask(TXH_LO, TXH_HI);
  localparam logic [DW-1:0] RX_MASK  = span_mask(RXH_LO, RXH_HI);
  localparam logic [DW-1:0] EVT_MASK = TX_MASK | RX_MASK;

  function automatic logic [DW-1:0] cfg_default(input int idx);
    case (idx)
      int'(CFG_TXLIST): return 32'hFFFF_FFFC;
      int'(CFG_RXLIST): return 32'hFFFF_FFFC;
      int'(CFG_FIFOTH): return 32'h0000_0101;
      int'(CFG_MAXRX):  return 32'h0000_0800;
      int'(CFG_MISS):   return 32'h0000_7FFF;
      int'(CFG_MDIO):   return 32'h0090_0000;
      default:          return '0;
    endcase
  endfunction

  // descriptor bases are word aligned
  function automatic logic [DW-1:0] cfg_wmask(input int idx);
    if (idx == int'(CFG_TXLIST) || idx == int'(CFG_RXLIST)) return 32'hFFFF_FFFC;
    return 32'hFFFF_FFFF;
  endfunction

  // write-one-to-clear with set priority
  function automatic logic [DW-1:0] w1c_update(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] clr,
                                               input logic [DW-1:0] set,
                                               input logic [DW-1:0] mask);
    return ((cur & ~clr) | set) & mask;
  endfunction

  function automatic logic any_pending(input logic [DW-1:0] stat,
                                       input logic [DW-1:0] ien,
                                       input logic [DW-1:0] mask);
    return |(stat & ien & mask);
  endfunction

endpackage

// File: rtl/maccsr_rst_seq.sv
`timescale 1ns/1ps
module maccsr_rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] left;
  logic          last_cyc;

  assign last_cyc = busy && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (busy) begin
      if (last_cyc) busy <= 1'b0;
      else          left <= left - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      left <= CW'(RST_CYCLES - 1);
    end
  end

  // checker: measure the busy window independently
  logic [CW-1:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_len <= '0;
    else if (busy) chk_len <= chk_len + 1'b1;
    else           chk_len <= '0;
  end

  a_r2_reset_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> chk_len == CW'(RST_CYCLES));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

// File: rtl/maccsr_cfg.sv
`timescale 1ns/1ps
module maccsr_cfg
  import maccsr_pkg::*;
#(
  parameter int N  = NCFG,
  parameter int IW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [IW-1:0]         idx,
  input  logic [DW-1:0]         wdata,
  output logic [N-1:0][DW-1:0]  q
);

  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q[g] <= cfg_default(g);
      else if (clr)                    q[g] <= cfg_default(g);
      else if (we && idx == IW'(g))    q[g] <= wdata & cfg_wmask(g);
    end

    a_r4_cfg_restore: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q[g] == cfg_default(g));
  end

endmodule

// File: rtl/maccsr_irq.sv
`timescale 1ns/1ps
module maccsr_irq
  import maccsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ien_we,
  input  logic          stat_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sts_set,
  output logic [DW-1:0] ien_q,
  output logic [DW-1:0] stat_q,
  output logic          irq_tx,
  output logic          irq_rx
);

  logic [DW-1:0] set_eff;
  logic [DW-1:0] clr_eff;

  assign set_eff = sts_set & EVT_MASK;
  assign clr_eff = stat_we ? (wdata & EVT_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else if (clr) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (ien_we) ien_q <= wdata & EVT_MASK;
      stat_q <= w1c_update(stat_q, clr_eff, set_eff, EVT_MASK);
    end
  end

  assign irq_tx = any_pending(stat_q, ien_q, TX_MASK);
  assign irq_rx = any_pending(stat_q, ien_q, RX_MASK);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && |set_eff) |=> (stat_q & $past(set_eff)) == $past(set_eff));

  a_r7_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stat_we) |=> (stat_q & $past(clr_eff & ~set_eff)) == '0);

  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!irq_tx && !irq_rx));

endmodule

// File: rtl/maccsr.sv
`timescale 1ns/1ps
module maccsr
  import maccsr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     sts_set,
  output logic              tx_en,
  output logic              rx_en,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int IW = $clog2(NCFG);

  logic                  rst_busy;
  logic                  wr_ok;
  logic                  hit_ctrl, hit_ien, hit_stat, hit_cfg;
  logic                  rst_start;
  logic                  clr_all;
  logic [IW-1:0]         cfg_idx;
  logic [DW-1:0]         ctrl_q;
  logic [DW-1:0]         ien_q, stat_q;
  logic [NCFG-1:0][DW-1:0] cfg_q;

  assign hit_ctrl  = int'(reg_addr) == A_CTRL;
  assign hit_ien   = int'(reg_addr) == A_IEN;
  assign hit_stat  = int'(reg_addr) == A_STAT;
  assign hit_cfg   = (int'(reg_addr) >= A_CFG0) && (int'(reg_addr) < A_CFG0 + NCFG);
  assign cfg_idx   = IW'(int'(reg_addr) - A_CFG0);

  assign wr_ok     = reg_we && !rst_busy;
  assign rst_start = wr_ok && hit_ctrl && reg_wdata[CTRL_RST_BIT];
  assign clr_all   = rst_start || rst_busy;

  maccsr_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rst_start),
    .busy  (rst_busy)
  );

  maccsr_cfg #(.N(NCFG), .IW(IW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .we    (wr_ok && hit_cfg),
    .idx   (cfg_idx),
    .wdata (reg_wdata),
    .q     (cfg_q)
  );

  maccsr_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .ien_we  (wr_ok && hit_ien),
    .stat_we (wr_ok && hit_stat),
    .wdata   (reg_wdata),
    .sts_set (sts_set),
    .ien_q   (ien_q),
    .stat_q  (stat_q),
    .irq_tx  (irq_tx),
    .irq_rx  (irq_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ctrl_q <= '0;
    else if (clr_all)         ctrl_q <= '0;
    else if (wr_ok && hit_ctrl) ctrl_q <= reg_wdata & CTRL_WMASK;
  end

  assign tx_en = ctrl_q[CTRL_TX_BIT];
  assign rx_en = ctrl_q[CTRL_RX_BIT];

  always_comb begin
    reg_rdata = '0;
    if (!rst_busy) begin
      if (hit_ctrl)      reg_rdata = ctrl_q;
      else if (hit_ien)  reg_rdata = ien_q;
      else if (hit_stat) reg_rdata = stat_q;
      else if (hit_cfg)  reg_rdata = cfg_q[cfg_idx];
    end
  end

  a_r3_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> reg_rdata == '0);

  a_r2_ctrl_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> (ctrl_q == '0 && !tx_en && !rx_en));

  a_r5_en_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && hit_ctrl && !reg_wdata[CTRL_RST_BIT]) |=>
      (tx_en == $past(reg_wdata[CTRL_TX_BIT]) && rx_en == $past(reg_wdata[CTRL_RX_BIT])));

  a_r4_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && $past(rst_busy)) |-> (ien_q == '0 && stat_q == '0));

endmodule

// File: tb/sim_maccsr.sv
`timescale 1ns/1ps
module sim_maccsr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] sts_set = '0;
  logic        tx_en, rx_en, irq_tx, irq_rx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  maccsr u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts_set(sts_set),
    .tx_en(tx_en), .rx_en(rx_en), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  // ---------------- reference model ----------------
  localparam logic [31:0] M_IMPL  = 32'h01FF_0FFF;
  localparam logic [31:0] M_TXH   = 32'h01FF_0000;
  localparam logic [31:0] M_RXH   = 32'h0000_0FFF;
  localparam int          M_RSTLEN = 16;

  logic [31:0] m_ctrl, m_ien, m_stat;
  logic [31:0] m_cfg [6];
  int          m_left;

  function automatic logic [31:0] dflt(input int i);
    logic [31:0] v [6] = '{32'hFFFFFFFC, 32'hFFFFFFFC, 32'h101, 32'h800, 32'h7FFF, 32'h00900000};
    return v[i];
  endfunction

  task automatic m_defaults();
    m_ctrl = 0; m_ien = 0; m_stat = 0;
    for (int i = 0; i < 6; i++) m_cfg[i] = dflt(i);
  endtask

  task automatic m_tick(input logic we, input int a, input logic [31:0] wd, input logic [31:0] set);
    logic [31:0] clr;
    if (m_left > 0) begin
      m_left--;
      return;
    end
    clr = 0;
    if (we && a == 0 && wd[24]) begin
      m_defaults();
      m_left = M_RSTLEN;
      return;
    end
    if (we) begin
      if (a == 0) m_ctrl = wd & 32'h00FFFFFF;
      else if (a == 1) m_ien = wd & M_IMPL;
      else if (a == 2) clr = wd;
      else if (a >= 3 && a <= 8) m_cfg[a-3] = wd & ((a <= 4) ? 32'hFFFFFFFC : 32'hFFFFFFFF);
    end
    m_stat = ((m_stat & ~clr) | set) & M_IMPL;
  endtask

  function automatic logic [31:0] m_read(input int a);
    if (m_left > 0) return 0;
    if (a == 0) return m_ctrl;
    if (a == 1) return m_ien;
    if (a == 2) return m_stat;
    if (a >= 3 && a <= 8) return m_cfg[a-3];
    return 0;
  endfunction

  function automatic logic [3:0] m_outs();
    logic it, ir;
    if (m_left > 0) return 4'b0;
    it = |(m_stat & m_ien & M_TXH);
    ir = |(m_stat & m_ien & M_RXH);
    return {it, ir, m_ctrl[8], m_ctrl[0]};
  endfunction

  // ---------------- checking ----------------
  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic we, input int a, input logic [31:0] wd,
                      input logic [31:0] set, input string tag);
    reg_we = we; reg_addr = a[3:0]; reg_wdata = wd; sts_set = set;
    @(posedge clk);
    m_tick(we, a, wd, set);
    @(negedge clk);
    reg_we = 0; sts_set = 0;
    #0.5;
    check(reg_rdata, m_read(a), tag, "rdata");
    check({28'b0, irq_tx, irq_rx, tx_en, rx_en}, {28'b0, m_outs()}, tag, "irq_tx/irq_rx/tx_en/rx_en");
  endtask

  initial begin
    #750000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    m_defaults();
    m_left = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values; R11 unmapped read zero
    for (int a = 0; a < 9; a++) step(0, a, 0, 0, "R1");
    for (int a = 9; a < 16; a++) step(0, a, 0, 0, "R11");
    step(1, 12, 32'hFFFFFFFF, 0, "R11");
    step(0, 12, 0, 0, "R11");

    // R5 control enables and masked bits
    step(1, 0, 32'hFEFF_FFFF, 0, "R5");
    step(1, 0, 32'h0000_0100, 0, "R5");
    step(1, 0, 32'h0000_0001, 0, "R5");
    // R10 aligned list bases
    step(1, 3, 32'hFFFF_FFFF, 0, "R10");
    step(1, 4, 32'h1234_5677, 0, "R10");
    // R6 implemented bits
    step(1, 1, 32'hFFFF_FFFF, 0, "R6");
    step(0, 2, 0, 32'hFFFF_FFFF, "R6");
    // R7 clear written ones only
    step(1, 2, 32'h0001_0001, 0, "R7");
    step(1, 2, 32'hFFFF_FFFF, 0, "R7");
    // R8 set wins over clear on the same edge
    step(0, 2, 0, 32'h0000_0020, "R8");
    step(1, 2, 32'h0000_0020, 32'h0000_0020, "R8");
    step(1, 2, 32'h0000_0020, 0, "R8");
    // R9 per-half gating
    step(1, 1, 32'h0000_0FFF, 0, "R9");
    step(0, 2, 0, 32'h0004_0000, "R9");
    step(1, 1, 32'h0004_0000, 0, "R9");
    step(1, 2, 32'h0004_0000, 32'h0000_0010, "R9");
    step(1, 1, 32'h0000_0010, 0, "R9");

    // R2/R3/R4 soft reset window
    step(1, 6, 32'hABCD_0000, 0, "R2");
    step(1, 0, 32'h0100_0101, 32'h0001_0001, "R2");
    step(1, 0, 32'h0100_0000, 0, "R4");
    for (int i = 0; i < 13; i++) step(1, i % 9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    step(0, 6, 0, 32'h0000_0001, "R4");
    step(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    for (int a = 0; a < 9; a++) step(0, a, 0, 0, "R2");

    // seeded random mix
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] wd;
      logic [31:0] set;
      logic we;
      int a;
      we = 1'($urandom);
      a = $urandom % 16;
      wd = $urandom;
      if ($urandom % 6 != 0) wd[24] = 1'b0;
      set = $urandom & $urandom & $urandom;
      step(we, a, wd, set, "R3 R4 R7 R8 R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule